// File: doc/BRIEF.md
# User-Mode Performance-Monitor Register Access Gate

This block stands between an instruction decoder and a small performance-monitor register file. It holds three 64-bit control registers and six 32-bit counters. When unprivileged code asks to move a value to or from one of these registers, the block decides whether the request may go ahead. A granted read returns data through a masked view. A granted write merges only the user-visible bits into the value already stored. A refused request leaves every register as it was and raises a fault strobe with a code that tells the two fault kinds apart.

The permission rules come from a two-bit counter-access field held at bits 19:18 of control register 0. Reads and writes follow separate rules. In one setting of the field, counters 5 and 6 leave the monitor and become unreachable. A supervisor port with no checks and no masks preloads state and reads it back.

User requests arrive on a valid/ready channel. Read data leaves on a second valid/ready channel that holds one entry. A request is taken only when the response slot is free, or is being emptied in the same cycle, and the supervisor port is idle. While a response is stalled, `req_ready` stays low, so back-pressure reaches the decoder. Fault reporting uses plain pins and cannot be stalled.

Top module: `pmu_access_gate`

## Requirements
- R1: After reset, every register reads as zero on the supervisor port, `req_ready` is 1, and `rsp_valid` and `fault_valid` are 0.
- R2: A user read is refused with facility-unavailable (code 0) when the access field is 01. It is granted when the field is 00, 10 or 11, apart from R4 and R10.
- R3: A user write is granted only when the access field is 10 or 11. With the field at 00 it faults with emulation-assist (code 1). With the field at 01 it faults with facility-unavailable (code 0).
- R4: With the access field at 11, any user read or write of counter 5 (user number 0x07) or counter 6 (user number 0x08) faults with code 0.
- R5: A user read of control register 0 (user number 0x0C) returns only bits 31, 26 and 25. A user write there changes only those three bits and keeps all others, the access field included.
- R6: For control register 2 (user number 0x01), only bits 0, 4, 8, 12, 16 and 20 are user-visible. All other bits read as zero and are kept on a user write.
- R7: The extra control register (user number 0x02) is read and written at full 64-bit width whenever the permission rules grant access.
- R8: User numbers below 0x10 alias supervisor numbers by adding 0x10. Counter k (1..6) is user number 0x02+k. Counters are 32 bits wide: reads return zero in bits 63:32, and writes keep data bits 31:0.
- R9: A refused request changes no register and produces no response. It raises `fault_valid` for exactly the one cycle after acceptance, with `fault_code` valid in that cycle.
- R10: A user number that maps to no register faults with code 1, whether it is a read or a write.
- R11: A granted read sets `rsp_valid` on the cycle after acceptance and holds `rsp_data` until `rsp_ready` is seen. A granted write commits at the accepting edge and produces no response. `req_ready` = not `sup_en` and not (`rsp_valid` and not `rsp_ready`).
- R12: The supervisor port uses the supervisor numbers 0x1C, 0x11, 0x12 and 0x13..0x18. It writes full width at the edge where `sup_en` and `sup_write` are high. `sup_rdata` shows the register selected by `sup_num` without delay, and reads 0 for an unmapped number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | User request present |
| req_ready | output | 1 | User request accepted this cycle |
| req_write | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| req_num | input | 10 | User register number |
| req_wdata | input | 64 | User write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_data | output | 64 | Masked read data |
| fault_valid | output | 1 | One-cycle refusal strobe |
| fault_code | output | 1 | 0 = facility unavailable, 1 = emulation assist |
| sup_en | input | 1 | Supervisor port active (blocks user requests) |
| sup_write | input | 1 | Supervisor write |
| sup_num | input | 10 | Supervisor register number |
| sup_wdata | input | 64 | Supervisor write data |
| sup_rdata | output | 64 | Supervisor read data, combinational |

## Verification
Every cycle, the assertions check the fault-code selection for the three permission cases: a read with the field at 01, a write with the field at 00, and the hidden counters with the field at 11. They also check that a write never produces a response, that a stalled response holds its data, and that a fault never appears alongside read data. Only the bench scenarios can show the masked read values, the bit-level merge of a user write into the old contents, the counter aliasing and 32-bit truncation, and the fact that a refused write leaves the target unchanged, because each of these needs a known preload and a supervisor readback.

// File: rtl/pmu_gate_pkg.sv
package pmu_gate_pkg;
  localparam int XLEN  = 64;
  localparam int CW    = 32;
  localparam int NUM_W = 10;
  localparam int NCTL  = 3;
  localparam int NCNT  = 6;
  localparam int NREG  = NCTL + NCNT;
  localparam int IDX_W = $clog2(NREG);
  localparam int FLD_LO = 18;
  localparam int HIDE_LO = 4;          // 0-based counter index of counter 5
  localparam int CTL2_STRIDE = 4;

  localparam logic [NUM_W-1:0] ALIAS_OFS = NUM_W'(16);
  localparam logic [NUM_W-1:0] P_CTL2    = NUM_W'(17);
  localparam logic [NUM_W-1:0] P_CTLA    = NUM_W'(18);
  localparam logic [NUM_W-1:0] P_CNT0    = NUM_W'(19);
  localparam logic [NUM_W-1:0] P_CTL0    = NUM_W'(28);

  localparam logic [IDX_W-1:0] I_CTL0 = IDX_W'(0);
  localparam logic [IDX_W-1:0] I_CTL2 = IDX_W'(1);
  localparam logic [IDX_W-1:0] I_CTLA = IDX_W'(2);
  localparam logic [IDX_W-1:0] I_CNT0 = IDX_W'(NCTL);

  localparam logic [XLEN-1:0] CTL0_UMASK = XLEN'(64'h0000_0000_8600_0000);

  function automatic logic [XLEN-1:0] ctl2_mask_f();
    logic [XLEN-1:0] m;
    m = '0;
    for (int k = 0; k < NCNT; k++) m[k*CTL2_STRIDE] = 1'b1;
    return m;
  endfunction
  localparam logic [XLEN-1:0] CTL2_UMASK = ctl2_mask_f();

  typedef enum logic {FLT_FACILITY = 1'b0, FLT_EMUL = 1'b1} flt_e;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
  } dec_t;

  function automatic dec_t priv_decode(input logic [NUM_W-1:0] n);
    dec_t d;
    d.hit = 1'b1;
    d.idx = I_CTL0;
    if (n == P_CTL0)      d.idx = I_CTL0;
    else if (n == P_CTL2) d.idx = I_CTL2;
    else if (n == P_CTLA) d.idx = I_CTLA;
    else if (n >= P_CNT0 && n < P_CNT0 + NUM_W'(NCNT))
      d.idx = I_CNT0 + IDX_W'(n - P_CNT0);
    else d.hit = 1'b0;
    return d;
  endfunction
endpackage

// File: rtl/pmu_gate_check.sv
module pmu_gate_check
  import pmu_gate_pkg::*;
(
  input  logic [NUM_W-1:0] num,
  input  logic             write,
  input  logic [1:0]       fld,
  output logic [IDX_W-1:0] idx,
  output logic             grant,
  output logic             refuse,
  output flt_e             code,
  output logic [XLEN-1:0]  umask
);
  dec_t dec;
  logic hidden;

  always_comb begin
    if (num < ALIAS_OFS) dec = priv_decode(num + ALIAS_OFS);
    else begin
      dec.hit = 1'b0;
      dec.idx = I_CTL0;
    end
  end

  assign idx    = dec.idx;
  assign hidden = (dec.idx >= I_CNT0 + IDX_W'(HIDE_LO)) &&
                  (dec.idx <  I_CNT0 + IDX_W'(HIDE_LO + 2));

  // permission and fault selection
  always_comb begin
    grant = 1'b0;
    code  = FLT_FACILITY;
    if (!dec.hit) code = FLT_EMUL;
    else if (hidden && fld == 2'b11) code = FLT_FACILITY;
    else if (write) begin
      if (fld[1]) grant = 1'b1;
      else if (fld[0]) code = FLT_FACILITY;
      else code = FLT_EMUL;
    end else begin
      if (fld != 2'b01) grant = 1'b1;
    end
  end
  assign refuse = !grant;

  always_comb begin
    if (dec.idx == I_CTL0)      umask = CTL0_UMASK;
    else if (dec.idx == I_CTL2) umask = CTL2_UMASK;
    else                        umask = '1;
  end
endmodule

// File: rtl/pmu_gate_regs.sv
module pmu_gate_regs
  import pmu_gate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [XLEN-1:0]  wdata,
  input  logic [XLEN-1:0]  wmask,
  input  logic [IDX_W-1:0] ridx_a,
  output logic [XLEN-1:0]  rdata_a,
  input  logic [IDX_W-1:0] ridx_b,
  output logic [XLEN-1:0]  rdata_b,
  output logic [1:0]       fld
);
  logic [XLEN-1:0] view [NREG];
  logic [XLEN-1:0] merged;

  always_comb merged = (view[widx < IDX_W'(NREG) ? widx : I_CTL0] & ~wmask) | (wdata & wmask);

  for (genvar g = 0; g < NCTL; g++) begin : g_ctl
    logic [XLEN-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else if (we && widx == IDX_W'(g)) q <= merged;
    end
    assign view[g] = q;
  end

  for (genvar c = 0; c < NCNT; c++) begin : g_cnt
    logic [CW-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else if (we && widx == IDX_W'(NCTL + c)) q <= merged[CW-1:0];
    end
    assign view[NCTL + c] = {{(XLEN-CW){1'b0}}, q};
  end

  assign rdata_a = (ridx_a < IDX_W'(NREG)) ? view[ridx_a] : '0;
  assign rdata_b = (ridx_b < IDX_W'(NREG)) ? view[ridx_b] : '0;
  assign fld     = view[I_CTL0][FLD_LO+1:FLD_LO];
endmodule

// File: rtl/pmu_gate_rsp.sv
module pmu_gate_rsp
  import pmu_gate_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc,
  input  logic            rd_grant,
  input  logic            refused,
  input  flt_e            code_in,
  input  logic [XLEN-1:0] data_in,
  input  logic            rsp_ready,
  output logic            rsp_valid,
  output logic [XLEN-1:0] rsp_data,
  output logic            fault_valid,
  output flt_e            fault_code,
  output logic            stall
);
  assign stall = rsp_valid && !rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_data    <= '0;
      fault_valid <= 1'b0;
      fault_code  <= FLT_FACILITY;
    end else begin
      if (acc && rd_grant) begin
        rsp_valid <= 1'b1;
        rsp_data  <= data_in;
      end else if (!stall) begin
        rsp_valid <= 1'b0;
      end
      fault_valid <= acc && refused;
      if (acc && refused) fault_code <= code_in;
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R11
  AST_FAULT_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> !rsp_valid); // R9
endmodule

// File: rtl/pmu_access_gate.sv
module pmu_access_gate
  import pmu_gate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [NUM_W-1:0] req_num,
  input  logic [XLEN-1:0]  req_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [XLEN-1:0]  rsp_data,
  output logic             fault_valid,
  output logic             fault_code,
  input  logic             sup_en,
  input  logic             sup_write,
  input  logic [NUM_W-1:0] sup_num,
  input  logic [XLEN-1:0]  sup_wdata,
  output logic [XLEN-1:0]  sup_rdata
);
  localparam logic [NUM_W-1:0] U_CTL0 = P_CTL0 - ALIAS_OFS;
  localparam logic [NUM_W-1:0] U_CNT5 = P_CNT0 + NUM_W'(HIDE_LO) - ALIAS_OFS;
  localparam logic [NUM_W-1:0] U_CNT6 = U_CNT5 + NUM_W'(1);

  logic [IDX_W-1:0] chk_idx;
  logic             chk_grant, chk_refuse;
  flt_e             chk_code, f_code;
  logic [XLEN-1:0]  chk_mask, rd_a, rd_b;
  logic [1:0]       fld;
  logic             stall, acc, sup_wr;
  dec_t             sdec;

  assign sdec   = priv_decode(sup_num);
  assign sup_wr = sup_en && sup_write && sdec.hit;
  assign req_ready = !sup_en && !stall;
  assign acc    = req_valid && req_ready;

  pmu_gate_check u_check (
    .num(req_num), .write(req_write), .fld(fld),
    .idx(chk_idx), .grant(chk_grant), .refuse(chk_refuse),
    .code(chk_code), .umask(chk_mask)
  );

  pmu_gate_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .we(sup_wr || (acc && req_write && chk_grant)),
    .widx(sup_wr ? sdec.idx : chk_idx),
    .wdata(sup_wr ? sup_wdata : req_wdata),
    .wmask(sup_wr ? {XLEN{1'b1}} : chk_mask),
    .ridx_a(chk_idx), .rdata_a(rd_a),
    .ridx_b(sdec.idx), .rdata_b(rd_b),
    .fld(fld)
  );

  assign sup_rdata = sdec.hit ? rd_b : '0;

  pmu_gate_rsp u_rsp (
    .clk(clk), .rst_n(rst_n), .acc(acc),
    .rd_grant(!req_write && chk_grant), .refused(chk_refuse),
    .code_in(chk_code), .data_in(rd_a & chk_mask),
    .rsp_ready(rsp_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .fault_valid(fault_valid), .fault_code(f_code), .stall(stall)
  );
  assign fault_code = f_code;

  AST_READ_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write && fld == 2'b01 && req_num == U_CTL0)
    |=> (fault_valid && fault_code == 1'b0)); // R2
  AST_WRITE_EMUL: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && fld == 2'b00) |=> (fault_valid && fault_code == 1'b1)); // R3
  AST_HIDDEN_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && fld == 2'b11 && (req_num == U_CNT5 || req_num == U_CNT6))
    |=> (fault_valid && fault_code == 1'b0)); // R4
  AST_WRITE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write) |=> !rsp_valid); // R11
endmodule

// File: tb/pmu_access_gate_tb.sv
`timescale 1ns/1ps
module pmu_access_gate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [9:0]  req_num = '0, sup_num = '0;
  logic [63:0] req_wdata = '0, sup_wdata = '0;
  logic        sup_en = 1'b0, sup_write = 1'b0;
  logic        req_ready, rsp_valid, fault_valid, fault_code;
  logic [63:0] rsp_data, sup_rdata;
  int tests = 0, fails = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  pmu_access_gate u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_num(req_num), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .fault_valid(fault_valid), .fault_code(fault_code),
    .sup_en(sup_en), .sup_write(sup_write), .sup_num(sup_num),
    .sup_wdata(sup_wdata), .sup_rdata(sup_rdata)
  );

  localparam logic [63:0] CTL0_BASE = 64'hFFFF_FFFF_FFF3_FFFF;
  localparam logic [63:0] CTLA_VAL  = 64'hAAAA_5555_0000_FFFF;

  typedef struct packed {
    logic [3:0]  req;
    logic [1:0]  fld;
    logic        wr;
    logic [9:0]  num;
    logic [63:0] wd;
    logic        flt;
    logic        code;
    logic [63:0] exp;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{4'd5,  2'b00, 1'b0, 10'h00C, 64'h0, 1'b0, 1'b0, 64'h0000_0000_8600_0000},  // R5 ctl0 read mask
    '{4'd2,  2'b01, 1'b0, 10'h003, 64'h0, 1'b1, 1'b0, 64'h0},                    // R2 read locked
    '{4'd6,  2'b10, 1'b0, 10'h001, 64'h0, 1'b0, 1'b0, 64'h0000_0000_0011_1111},  // R6 ctl2 read mask
    '{4'd7,  2'b11, 1'b0, 10'h002, 64'h0, 1'b0, 1'b0, CTLA_VAL},                 // R7 extra read
    '{4'd4,  2'b11, 1'b0, 10'h007, 64'h0, 1'b1, 1'b0, 64'h0},                    // R4 cnt5 hidden
    '{4'd4,  2'b11, 1'b0, 10'h008, 64'h0, 1'b1, 1'b0, 64'h0},                    // R4 cnt6 hidden
    '{4'd8,  2'b10, 1'b0, 10'h008, 64'h0, 1'b0, 1'b0, 64'h0000_0000_1000_0006},  // R8 alias cnt6
    '{4'd3,  2'b00, 1'b1, 10'h003, 64'h5, 1'b1, 1'b1, 64'h0000_0000_1000_0001},  // R3 R9 emul, unchanged
    '{4'd3,  2'b01, 1'b1, 10'h001, 64'h0, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF},  // R3 R9 facility
    '{4'd5,  2'b10, 1'b1, 10'h00C, 64'h0, 1'b0, 1'b0, 64'hFFFF_FFFF_79FB_FFFF},  // R5 merge
    '{4'd6,  2'b11, 1'b1, 10'h001, 64'h0, 1'b0, 1'b0, 64'hFFFF_FFFF_FFEE_EEEE},  // R6 merge
    '{4'd8,  2'b10, 1'b1, 10'h004, 64'hDEAD_BEEF_1234_5678, 1'b0, 1'b0, 64'h0000_0000_1234_5678}, // R8 truncation
    '{4'd4,  2'b11, 1'b1, 10'h007, 64'h55, 1'b1, 1'b0, 64'h0000_0000_1000_0005}, // R4 write hidden
    '{4'd4,  2'b10, 1'b1, 10'h007, 64'h55, 1'b0, 1'b0, 64'h0000_0000_0000_0055}, // R4 visible at 10
    '{4'd10, 2'b10, 1'b0, 10'h009, 64'h0, 1'b1, 1'b1, 64'h0},                    // R10 unmapped read
    '{4'd10, 2'b11, 1'b1, 10'h020, 64'h0, 1'b1, 1'b1, 64'h0},                    // R10 unmapped write
    '{4'd7,  2'b11, 1'b1, 10'h002, 64'h1234, 1'b0, 1'b0, 64'h0000_0000_0000_1234}, // R7 extra write
    '{4'd2,  2'b01, 1'b0, 10'h00C, 64'h0, 1'b1, 1'b0, 64'h0},                    // R2 read locked ctl0
    '{4'd2,  2'b00, 1'b0, 10'h005, 64'h0, 1'b0, 1'b0, 64'h0000_0000_1000_0003}   // R2 read open at 00
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sup_wr(input logic [9:0] n, input logic [63:0] d);
    @(negedge clk);
    sup_en = 1'b1; sup_write = 1'b1; sup_num = n; sup_wdata = d;
    @(negedge clk);
    sup_en = 1'b0; sup_write = 1'b0;
  endtask

  task automatic preload(input logic [1:0] f);
    sup_wr(10'h011, 64'hFFFF_FFFF_FFFF_FFFF);
    sup_wr(10'h012, CTLA_VAL);
    for (int k = 1; k <= 6; k++) sup_wr(10'h012 + 10'(k), 64'h1000_0000 + 64'(k));
    sup_wr(10'h01C, CTL0_BASE | (64'(f) << 18));
  endtask

  task automatic issue(input logic wr, input logic [9:0] n, input logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_num = n; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 req_ready", 64'(req_ready), 64'd1);
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 fault_valid", 64'(fault_valid), 64'd0);
    sup_num = 10'h01C; #1 chk("R1 ctl0 zero", sup_rdata, 64'h0);
    sup_num = 10'h018; #1 chk("R1 cnt6 zero", sup_rdata, 64'h0);

    for (int i = 0; i < NV; i++) begin
      preload(VEC[i].fld);
      issue(VEC[i].wr, VEC[i].num, VEC[i].wd);
      if (VEC[i].flt) begin
        chk($sformatf("R%0d vec%0d fault", VEC[i].req, i), 64'(fault_valid), 64'd1);
        chk($sformatf("R%0d vec%0d code", VEC[i].req, i), 64'(fault_code), 64'(VEC[i].code));
        chk($sformatf("R%0d vec%0d no rsp", VEC[i].req, i), 64'(rsp_valid), 64'd0);
      end else if (!VEC[i].wr) begin
        chk($sformatf("R%0d vec%0d rsp_valid", VEC[i].req, i), 64'(rsp_valid), 64'd1);
        chk($sformatf("R%0d vec%0d data", VEC[i].req, i), rsp_data, VEC[i].exp);
        chk($sformatf("R%0d vec%0d no fault", VEC[i].req, i), 64'(fault_valid), 64'd0);
      end else begin
        chk($sformatf("R%0d vec%0d wr no fault", VEC[i].req, i), 64'(fault_valid), 64'd0);
        chk($sformatf("R11 vec%0d wr no rsp", i), 64'(rsp_valid), 64'd0);
      end
      if (VEC[i].wr && VEC[i].num < 10'h010) begin
        sup_num = VEC[i].num + 10'h010;
        #1 chk($sformatf("R%0d vec%0d readback", VEC[i].req, i), sup_rdata, VEC[i].exp);
      end
    end

    // R9 fault strobe lasts one cycle
    preload(2'b01);
    issue(1'b0, 10'h003, 64'h0);
    chk("R9 fault high", 64'(fault_valid), 64'd1);
    @(negedge clk);
    chk("R9 fault one cycle", 64'(fault_valid), 64'd0);

    // R12 supervisor port: unmapped reads zero, full width
    sup_num = 10'h3FF; #1 chk("R12 unmapped sup read", sup_rdata, 64'h0);
    sup_num = 10'h012; #1 chk("R12 full width", sup_rdata, CTLA_VAL);

    // R11 sup_en blocks requests
    @(negedge clk);
    sup_en = 1'b1; sup_write = 1'b0;
    #1 chk("R11 sup_en blocks", 64'(req_ready), 64'd0);
    sup_en = 1'b0;

    // R11 back-pressure
    preload(2'b10);
    rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_num = 10'h002;
    @(negedge clk);
    req_num = 10'h003;
    chk("R11 rsp after accept", 64'(rsp_valid), 64'd1);
    chk("R11 ready low while stalled", 64'(req_ready), 64'd0);
    repeat (2) @(negedge clk);
    chk("R11 held valid", 64'(rsp_valid), 64'd1);
    chk("R11 held data", rsp_data, CTLA_VAL);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 next rsp", rsp_data, 64'h0000_0000_1000_0001);
    chk("R8 cnt1 alias", 64'(rsp_valid), 64'd1);
    @(negedge clk);
    chk("R11 rsp drained", 64'(rsp_valid), 64'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule